// File: doc/BRIEF.md
# Status Flag and Branch Decision Unit

This block performs one of a small set of 8-bit operations (addition, subtraction, bitwise AND, and the compare and test forms of the last two) and derives four status flags from the outcome: carry, sign, zero and overflow. The flags are held in a register. A separate condition code, presented on every cycle, is evaluated against that register to produce a registered branch-taken decision. A sequencer uses the decision to choose between the next in-line address and a branch target.

The carry and overflow flags come from the two most significant carries of a ripple adder. Subtraction adds the inverted second operand with a carry-in of one, so a set carry after a subtraction means that no borrow occurred. A single condition decoder handles three kinds of condition: tests of a single flag, unsigned relations after A−B, and signed relations after A−B. Compare and test change the flags but do not write back a result, so the result register keeps its previous value.

The operation is sampled when `op_valid` is high. Legal operation codes are 0 ADD, 1 SUB, 2 AND, 3 CMP and 4 TST. Codes 5 to 7 do nothing.

Top module: `flag_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q`, `wb_en_q`, all four flags and `take_q` are 0 after that edge.
- R2: A valid ADD (code 0) loads `res_q` with (A+B) mod 256 and sets `wb_en_q` to 1 on the same edge. C is then the carry out of bit 7.
- R3: A valid SUB (code 1) loads `res_q` with A+~B+1 mod 256 and sets `wb_en_q`. C is 1 exactly when A ≥ B as unsigned numbers (no borrow).
- R4: A valid AND (code 2) loads `res_q` with A&B and sets `wb_en_q`. C and V are cleared.
- R5: A valid CMP (code 3, A−B) or TST (code 4, A&B) updates the flags as SUB or AND would, drives `wb_en_q` to 0, and leaves `res_q` unchanged.
- R6: After any flag update, S equals bit 7 of the operation's result, and Z is 1 exactly when all 8 result bits are 0.
- R7: After ADD, SUB or CMP, V is 1 exactly when the operation overflowed as a two's-complement operation, which is the XOR of the carry into bit 7 and the carry out of bit 7.
- R8: When `op_valid` is low, or the code is 5, 6 or 7, the flags and `res_q` keep their values and `wb_en_q` is 0.
- R9: Condition codes 0 to 7 test a single flag: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 S=0, 5 S=1, 6 V=1, 7 V=0. Codes 0 and 1 also serve as equal and not-equal, and codes 2 and 3 as unsigned higher-or-equal and lower.
- R10: Unsigned relations after A−B: code 8 (higher) is C=1 and Z=0, and code 9 (lower-or-equal) is C=0 or Z=1.
- R11: Signed relations after A−B: code 10 (greater-or-equal) is S XOR V = 0, code 11 (less) is S XOR V = 1, code 12 (greater) is S XOR V = 0 and Z=0, and code 13 (less-or-equal) is S XOR V = 1 or Z=1.
- R12: Condition codes 14 and 15 never produce a taken branch.
- R13: `take_q` after an edge reflects `cond_in` applied to the flags that were held before that edge. An operation on the same edge does not affect the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code (0 ADD, 1 SUB, 2 AND, 3 CMP, 4 TST) |
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| cond_in | input | 4 | Branch condition code |
| res_q | output | 8 | Registered result |
| wb_en_q | output | 1 | Result written this edge (ADD, SUB, AND) |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| take_q | output | 1 | Registered branch-taken decision |

## Verification
The bench builds the block with its default 8-bit data width, so the complete operand space is within reach. This includes the signed boundary values 0x7F and 0x80, the all-ones value and equal operands, where the zero, carry and overflow flags each switch. Directed compares on those values check every relational condition code against a plain unsigned or signed comparison of the operands. Random operations, including illegal codes and idle cycles, mixed with random condition codes also exercise the one-cycle lag between a flag update and the decision that uses it.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int COND_W = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_CMP = 3'd3,
    OP_TST = 3'd4
  } op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  localparam logic [COND_W-1:0] CC_ZSET = 4'd0;
  localparam logic [COND_W-1:0] CC_ZCLR = 4'd1;
  localparam logic [COND_W-1:0] CC_CSET = 4'd2;
  localparam logic [COND_W-1:0] CC_CCLR = 4'd3;
  localparam logic [COND_W-1:0] CC_SCLR = 4'd4;
  localparam logic [COND_W-1:0] CC_SSET = 4'd5;
  localparam logic [COND_W-1:0] CC_VSET = 4'd6;
  localparam logic [COND_W-1:0] CC_VCLR = 4'd7;
  localparam logic [COND_W-1:0] CC_UHI  = 4'd8;
  localparam logic [COND_W-1:0] CC_ULS  = 4'd9;
  localparam logic [COND_W-1:0] CC_SGE  = 4'd10;
  localparam logic [COND_W-1:0] CC_SLT  = 4'd11;
  localparam logic [COND_W-1:0] CC_SGT  = 4'd12;
  localparam logic [COND_W-1:0] CC_SLE  = 4'd13;
endpackage

// File: rtl/fbu_adder.sv
module fbu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         c_msb_in
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  assign c_out    = carry[W];
  assign c_msb_in = carry[W-1];

  // R7: the XOR of the top two carries must agree with sign-based overflow detection
  always_comb begin
    if (!$isunknown({x, y, cin})) begin
      a_r7_overflow_match: assert ((c_out ^ c_msb_in) ==
        ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])))
        else $error("overflow carry pair disagrees with sign rule");
    end
  end
endmodule

// File: rtl/fbu_datapath.sv
module fbu_datapath
  import fbu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output flags_t       flags_nx,
  output logic         writes,
  output logic         legal
);
  logic         is_sub;
  logic         is_logic;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         c_top;
  logic         c_pre;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_TST);
    legal    = (op <= 3'(OP_TST));
    writes   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
    b_eff    = is_sub ? ~b : b;
  end

  fbu_adder #(.W(W)) u_add (
    .x        (a),
    .y        (b_eff),
    .cin      (is_sub),
    .sum      (sum),
    .c_out    (c_top),
    .c_msb_in (c_pre)
  );

  always_comb begin
    result     = is_logic ? (a & b) : sum;
    flags_nx.c = is_logic ? 1'b0 : c_top;
    flags_nx.v = is_logic ? 1'b0 : (c_top ^ c_pre);
    flags_nx.s = result[W-1];
    flags_nx.z = (result == '0);
  end
endmodule

// File: rtl/fbu_cond.sv
module fbu_cond
  import fbu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            fl,
  output logic              take
);
  logic sv_lt;

  always_comb begin
    sv_lt = fl.s ^ fl.v;
    case (cond)
      CC_ZSET: take = fl.z;
      CC_ZCLR: take = !fl.z;
      CC_CSET: take = fl.c;
      CC_CCLR: take = !fl.c;
      CC_SCLR: take = !fl.s;
      CC_SSET: take = fl.s;
      CC_VSET: take = fl.v;
      CC_VCLR: take = !fl.v;
      CC_UHI:  take = fl.c && !fl.z;
      CC_ULS:  take = !fl.c || fl.z;
      CC_SGE:  take = !sv_lt;
      CC_SLT:  take = sv_lt;
      CC_SGT:  take = !sv_lt && !fl.z;
      CC_SLE:  take = sv_lt || fl.z;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import fbu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [COND_W-1:0] cond_in,
  output logic [DATA_W-1:0] res_q,
  output logic              wb_en_q,
  output logic              flag_c,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_v,
  output logic              take_q
);
  logic [DATA_W-1:0] result;
  flags_t            flags_nx;
  flags_t            flags_q;
  logic              writes;
  logic              legal;
  logic              take_d;

  fbu_datapath #(.W(DATA_W)) u_dp (
    .op       (op_sel),
    .a        (a_in),
    .b        (b_in),
    .result   (result),
    .flags_nx (flags_nx),
    .writes   (writes),
    .legal    (legal)
  );

  fbu_cond u_cond (
    .cond (cond_in),
    .fl   (flags_q),
    .take (take_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      wb_en_q <= 1'b0;
      flags_q <= '0;
      take_q  <= 1'b0;
    end else begin
      take_q  <= take_d;
      wb_en_q <= op_valid && writes;
      if (op_valid && legal)  flags_q <= flags_nx;
      if (op_valid && writes) res_q   <= result;
    end
  end

  assign flag_c = flags_q.c;
  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;

  // R5: compare and test never touch the result and never write back
  a_r5_cmp_keeps_result: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_CMP || op_sel == OP_TST)) |=> ($stable(res_q) && !wb_en_q));

  // R8: idle or illegal codes leave the flags alone
  a_r8_idle_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel > 3'(OP_TST)) |=> ($stable({flag_c, flag_s, flag_z, flag_v}) && !wb_en_q));

  // R4: logical operations clear carry and overflow
  a_r4_and_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_AND || op_sel == OP_TST)) |=> (!flag_c && !flag_v));

  // R12: unused condition codes are never taken
  a_r12_unused_not_taken: assert property (@(posedge clk) disable iff (rst)
    (cond_in >= 4'd14) |=> !take_q);

  // R2: a writing operation raises the write-back enable
  a_r2_wb_on_write: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel <= 3'(OP_AND)) |=> wb_en_q);

  // R6: a zero result register after a write implies the zero flag
  a_r6_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
    wb_en_q |-> (flag_z == (res_q == '0)));
endmodule

// File: tb/tb_flag_branch_unit.sv
module tb_flag_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [2:0]   op_sel = 3'd0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [3:0]   cond_in = 4'd0;
  logic [W-1:0] res_q;
  logic         wb_en_q, flag_c, flag_s, flag_z, flag_v, take_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] m_res = '0;
  logic m_wb = 0, m_c = 0, m_s = 0, m_z = 0, m_v = 0, m_take = 0;

  flag_branch_unit #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .a_in(a_in), .b_in(b_in), .cond_in(cond_in),
    .res_q(res_q), .wb_en_q(wb_en_q), .flag_c(flag_c), .flag_s(flag_s),
    .flag_z(flag_z), .flag_v(flag_v), .take_q(take_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_take(input logic [3:0] k, input logic c, s, z, v);
    logic neg_ovf;
    neg_ovf = (s != v);
    case (k)
      4'd0: return z;           4'd1: return !z;
      4'd2: return c;           4'd3: return !c;
      4'd4: return !s;          4'd5: return s;
      4'd6: return v;           4'd7: return !v;
      4'd8: return c && !z;     4'd9: return !c || z;
      4'd10: return !neg_ovf;   4'd11: return neg_ovf;
      4'd12: return !neg_ovf && !z;
      4'd13: return neg_ovf || z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic relation(input logic [3:0] k, input logic [W-1:0] a, b);
    case (k)
      4'd0: return a == b;      4'd1: return a != b;
      4'd2: return a >= b;      4'd3: return a < b;
      4'd8: return a > b;       4'd9: return a <= b;
      4'd10: return $signed(a) >= $signed(b);
      4'd11: return $signed(a) <  $signed(b);
      4'd12: return $signed(a) >  $signed(b);
      4'd13: return $signed(a) <= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string res_tag(input logic v, input logic [2:0] op);
    if (!v || op > 3'd4) return "R8";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string take_tag(input logic [3:0] k);
    if (k <= 4'd7) return "R9 R13";
    if (k <= 4'd9) return "R10 R13";
    if (k <= 4'd13) return "R11 R13";
    return "R12";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [W-1:0] a, b,
                      input logic [3:0] k);
    logic [W:0]   wide;
    logic [W-1:0] r;
    @(negedge clk);
    op_valid = v; op_sel = op; a_in = a; b_in = b; cond_in = k;
    m_take = exp_take(k, m_c, m_s, m_z, m_v);
    m_wb = 0;
    if (v && op <= 3'd4) begin
      case (op)
        3'd0:      wide = {1'b0, a} + {1'b0, b};
        3'd1, 3'd3: wide = {1'b0, a} + {1'b0, ~b} + 1;
        default:   wide = {1'b0, a & b};
      endcase
      r = wide[W-1:0];
      if (op == 3'd0)
        m_v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      else if (op == 3'd1 || op == 3'd3)
        m_v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      else
        m_v = 0;
      m_c = (op == 3'd2 || op == 3'd4) ? 1'b0 : wide[W];
      m_s = r[W-1];
      m_z = (r == '0);
      if (op <= 3'd2) begin m_res = r; m_wb = 1; end
    end
    @(posedge clk);
    #1;
    chk(res_tag(v, op), 32'(res_q), 32'(m_res));
    chk(res_tag(v, op), 32'(wb_en_q), 32'(m_wb));
    chk("R6 R7 flags", {28'd0, flag_c, flag_s, flag_z, flag_v}, {28'd0, m_c, m_s, m_z, m_v});
    chk(take_tag(k), 32'(take_q), 32'(m_take));
  endtask

  task automatic rel_check(input logic [W-1:0] a, b);
    step(1'b1, 3'd3, a, b, 4'd15);
    for (int k = 0; k < 14; k++) begin
      if (k >= 4 && k <= 7) continue;
      step(1'b0, 3'd0, '0, '0, 4'(k));
      chk(k < 4 ? "R9 relation" : (k < 10 ? "R10 relation" : "R11 relation"),
          32'(take_q), 32'(relation(4'(k), a, b)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b1; op_sel = 3'd0; a_in = 8'h80; b_in = 8'h80; cond_in = 4'd1;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0; op_valid = 1'b0;
    chk("R1 res", 32'(res_q), 32'd0);
    chk("R1 ctl", {28'd0, wb_en_q, take_q, flag_c, flag_z}, 32'd0);
    chk("R1 sv", {30'd0, flag_s, flag_v}, 32'd0);
    m_res = '0; m_c = 0; m_s = 0; m_z = 0; m_v = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    do_reset();

    // R2 R7: signed overflow and carry corners
    step(1'b1, 3'd0, 8'h7F, 8'h01, 4'd6);
    step(1'b1, 3'd0, 8'hFF, 8'h01, 4'd6);
    step(1'b1, 3'd0, 8'h80, 8'h80, 4'd0);
    // R3: subtraction with and without borrow
    step(1'b1, 3'd1, 8'h05, 8'h07, 4'd2);
    step(1'b1, 3'd1, 8'h80, 8'h01, 4'd3);
    // R4: AND clears carry and overflow
    step(1'b1, 3'd2, 8'hF0, 8'h0F, 4'd6);
    // R5: CMP and TST keep result
    step(1'b1, 3'd3, 8'h10, 8'h10, 4'd0);
    step(1'b1, 3'd4, 8'hAA, 8'h55, 4'd0);
    // R13: decision lags flags by one edge
    step(1'b1, 3'd3, 8'h01, 8'h02, 4'd0);
    // R8: illegal codes and idle
    step(1'b1, 3'd5, 8'h00, 8'h00, 4'd3);
    step(1'b1, 3'd7, 8'h12, 8'h34, 4'd14);
    step(1'b0, 3'd0, 8'h12, 8'h34, 4'd15);

    // R10 R11: relations on boundary operand pairs
    rel_check(8'h00, 8'h00);
    rel_check(8'h7F, 8'h80);
    rel_check(8'h80, 8'h7F);
    rel_check(8'hFF, 8'h01);
    rel_check(8'h01, 8'hFF);
    rel_check(8'h80, 8'h80);
    for (int i = 0; i < 40; i++) rel_check(8'($urandom), 8'($urandom));

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, 3'($urandom), 8'($urandom), 8'($urandom), 4'($urandom));
      if (i == 1500) do_reset();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule